// File: doc/BRIEF.md
# Smart Card Early Answer Detector

This block watches a smart card's data line and reset line while the card is being brought out of reset. Its job is to notice a card that starts answering too soon. It counts card clock cycles in two separate phases. The first phase starts when reset falls. The second starts when reset rises. The data line is only looked at on sampling ticks that come once every fixed number of card clocks. On each tick the block checks for a start bit, seen as a high-to-low transition from one tick to the next.

Each start bit it detects is classified by its phase and its cycle position:
- In some positions the start bit sets a sticky early-answer flag. That flag also drives the interrupt line.
- In the blind interval at the end of each flagging window, the start bit is accepted as a character but not flagged.
- Very early in the reset-low phase, the start bit is ignored altogether.

A separate output tells the receive path whether a start bit at the present position would be taken as a character. The host clears the flag with a one-cycle strobe.

Top module: `scea_detector`

## Requirements
- R1: While the card reset is low, a start bit detected at cycle position below 200 leaves the flag clear, and char_accept is 0 at every position below 200 in that phase.
- R2: While the card reset is low, a start bit detected at position 200 up to, but not including, 336 sets the flag on the clock edge that samples it.
- R3: The last 32 cycles of each flagging window (positions 336 and up) are blind. A start bit detected there leaves the flag clear, and char_accept is 1.
- R4: After the card reset rises, a start bit detected at position below 336 sets the flag.
- R5: After the card reset rises, char_accept is 1 at every position. A start bit at position 336 or later, including the saturated position 400, leaves the flag clear.
- R6: The data line is sampled only on every 46th enabled card clock of a phase, which is the enable at position 45, 91, 137 and so on. A start bit is a sample of 0 that follows a sample of 1. A reset edge makes the previous sample count as 1, and a low level that falls entirely between ticks is never seen.
- R7: The cycle position restarts at 0 on every edge of the card reset. It advances only on clock cycles where clk_en is 1, and it saturates at 400.
- R8: The flag is sticky until ea_clr is pulsed. If a set and a clear land in the same cycle, the set wins.
- R9: irq is 1 exactly when the flag is 1.
- R10: After the synchronous reset, ea_flag, irq and char_accept are all 0, as long as card_rst is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | One pulse per card clock cycle |
| card_rst | input | 1 | Level of the card reset line |
| io_line | input | 1 | Level of the card data line |
| ea_clr | input | 1 | Host strobe that clears the flag |
| ea_flag | output | 1 | Sticky early-answer flag |
| irq | output | 1 | Interrupt, high while the flag is set |
| char_accept | output | 1 | A start bit at the present position would be received |

## Verification
The hardest cases to reach from the ports are the classification boundaries. The transition has to land exactly on a sampling tick whose position sits just inside or just outside a window, and positions are counted in enabled clocks, not system clocks. The bench handles this by re-entering each phase with a fresh reset edge and counting enables itself. It drops the data line during the cycle just before the chosen tick, and it sweeps every tick from position 45 past saturation in both phases. A separate run with clk_en gating every other cycle tells apart a counter that advances on enables from one that advances on clocks.

// File: rtl/scea_pkg.sv
package scea_pkg;

    localparam int unsigned SCEA_LO_START   = 200;
    localparam int unsigned SCEA_WIN_END    = 368;
    localparam int unsigned SCEA_BLIND      = 32;
    localparam int unsigned SCEA_ANS_START  = 400;
    localparam int unsigned SCEA_SAMPLE_PER = 46;

    typedef enum logic [1:0] {
        V_IGNORE = 2'd0,
        V_FLAG   = 2'd1,
        V_ACCEPT = 2'd2
    } verdict_t;

    // Classify a detected start bit by phase and cycle position.
    function automatic verdict_t classify(
        input logic        hi,
        input int unsigned pos,
        input int unsigned lo_start,
        input int unsigned win_end,
        input int unsigned blind
    );
        verdict_t v;
        if (!hi && pos < lo_start)
            v = V_IGNORE;
        else if (pos < win_end - blind)
            v = V_FLAG;
        else
            v = V_ACCEPT;
        return v;
    endfunction

endpackage

// File: rtl/scea_phase_timer.sv
module scea_phase_timer #(
    parameter int unsigned CNT_MAX    = scea_pkg::SCEA_ANS_START,
    parameter int unsigned SAMPLE_PER = scea_pkg::SCEA_SAMPLE_PER,
    localparam int unsigned CW        = $clog2(CNT_MAX + 1),
    localparam int unsigned SW        = $clog2(SAMPLE_PER)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          card_rst,
    output logic          phase_hi,
    output logic          edge_seen,
    output logic [CW-1:0] cnt,
    output logic          tick
);
    logic [SW-1:0] samp;
    logic          samp_last;

    assign edge_seen = (card_rst != phase_hi);
    assign samp_last = (samp == SW'(SAMPLE_PER - 1));
    assign tick      = clk_en && !edge_seen && samp_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
            samp     <= '0;
        end else begin
            phase_hi <= card_rst;
            if (edge_seen) begin
                cnt  <= '0;
                samp <= '0;
            end else if (clk_en) begin
                if (cnt != CW'(CNT_MAX))
                    cnt <= cnt + 1'b1;
                samp <= samp_last ? '0 : samp + 1'b1;
            end
        end
    end

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> (cnt == '0));

    p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(CNT_MAX) && !edge_seen) |=> (cnt == CW'(CNT_MAX)));

    p_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (!clk_en && !edge_seen) |=> $stable(cnt));

endmodule

// File: rtl/scea_start_sampler.sv
module scea_start_sampler (
    input  logic clk,
    input  logic rst,
    input  logic edge_seen,
    input  logic tick,
    input  logic io_line,
    output logic start_det
);
    logic prev_hi;

    assign start_det = tick && prev_hi && !io_line;

    always_ff @(posedge clk) begin
        if (rst)
            prev_hi <= 1'b1;
        else if (edge_seen)
            prev_hi <= 1'b1;
        else if (tick)
            prev_hi <= io_line;
    end

    p_no_repeat_r6: assert property (@(posedge clk) disable iff (rst)
        (start_det && !edge_seen) |=> !prev_hi);

endmodule

// File: rtl/scea_status.sv
module scea_status
    import scea_pkg::*;
#(
    parameter int unsigned LO_START = SCEA_LO_START,
    parameter int unsigned WIN_END  = SCEA_WIN_END,
    parameter int unsigned BLIND    = SCEA_BLIND,
    parameter int unsigned CW       = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_det,
    input  logic          phase_hi,
    input  logic [CW-1:0] cnt,
    input  logic          ea_clr,
    output logic          ea_q,
    output logic          accept
);
    localparam int unsigned FLAG_END = WIN_END - BLIND;

    verdict_t verdict;

    assign verdict = classify(phase_hi, 32'(cnt), LO_START, WIN_END, BLIND);
    assign accept  = (verdict != V_IGNORE);

    always_ff @(posedge clk) begin
        if (rst)
            ea_q <= 1'b0;
        else if (start_det && verdict == V_FLAG)
            ea_q <= 1'b1;
        else if (ea_clr)
            ea_q <= 1'b0;
    end

    p_ignore_early_r1: assert property (@(posedge clk) disable iff (rst)
        (start_det && !phase_hi && 32'(cnt) < LO_START && !ea_q) |=> !ea_q);

    p_set_low_r2: assert property (@(posedge clk) disable iff (rst)
        (start_det && !phase_hi && 32'(cnt) >= LO_START && 32'(cnt) < FLAG_END) |=> ea_q);

    p_blind_r3: assert property (@(posedge clk) disable iff (rst)
        (start_det && 32'(cnt) >= FLAG_END && !ea_q) |=> !ea_q);

    p_set_high_r4: assert property (@(posedge clk) disable iff (rst)
        (start_det && phase_hi && 32'(cnt) < FLAG_END) |=> ea_q);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (ea_q && !ea_clr) |=> ea_q);

    p_accept_high_r5: assert property (@(posedge clk) disable iff (rst)
        phase_hi |-> accept);

endmodule

// File: rtl/scea_detector.sv
module scea_detector
    import scea_pkg::*;
#(
    parameter int unsigned LO_START   = SCEA_LO_START,
    parameter int unsigned WIN_END    = SCEA_WIN_END,
    parameter int unsigned BLIND      = SCEA_BLIND,
    parameter int unsigned ANS_START  = SCEA_ANS_START,
    parameter int unsigned SAMPLE_PER = SCEA_SAMPLE_PER
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_en,
    input  logic card_rst,
    input  logic io_line,
    input  logic ea_clr,
    output logic ea_flag,
    output logic irq,
    output logic char_accept
);
    localparam int unsigned CW = $clog2(ANS_START + 1);

    logic          phase_hi;
    logic          edge_seen;
    logic [CW-1:0] cnt;
    logic          tick;
    logic          start_det;
    logic          ea_q;
    logic          accept;

    scea_phase_timer #(
        .CNT_MAX   (ANS_START),
        .SAMPLE_PER(SAMPLE_PER)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .card_rst (card_rst),
        .phase_hi (phase_hi),
        .edge_seen(edge_seen),
        .cnt      (cnt),
        .tick     (tick)
    );

    scea_start_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .edge_seen(edge_seen),
        .tick     (tick),
        .io_line  (io_line),
        .start_det(start_det)
    );

    scea_status #(
        .LO_START(LO_START),
        .WIN_END (WIN_END),
        .BLIND   (BLIND),
        .CW      (CW)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .start_det(start_det),
        .phase_hi (phase_hi),
        .cnt      (cnt),
        .ea_clr   (ea_clr),
        .ea_q     (ea_q),
        .accept   (accept)
    );

    assign ea_flag     = ea_q;
    assign irq         = ea_q;
    assign char_accept = accept;

endmodule

// File: tb/tb_scea_detector.sv
`timescale 1ns/1ps
module tb_scea_detector;
    logic clk = 1'b0;
    logic rst, clk_en, card_rst, io_line, ea_clr;
    logic ea_flag, irq, char_accept;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    always #10 clk = ~clk;

    scea_detector dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .card_rst(card_rst),
        .io_line(io_line), .ea_clr(ea_clr), .ea_flag(ea_flag),
        .irq(irq), .char_accept(char_accept)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic int unsigned sat(input int unsigned m);
        return (m > 400) ? 400 : m;
    endfunction

    function automatic logic exp_flag(input bit hi, input int unsigned c);
        return hi ? (c < 336) : (c >= 200 && c < 336);
    endfunction

    // Clears the flag and enters a fresh phase; returns right after the edge cycle.
    task automatic enter_phase(input bit hi);
        io_line  = 1'b1;
        clk_en   = 1'b1;
        card_rst = !hi;
        ea_clr   = 1'b1;
        @(negedge clk);
        ea_clr   = 1'b0;
        repeat (2) @(negedge clk);
        card_rst = hi;
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; clk_en = 1'b0; card_rst = 1'b0; io_line = 1'b1; ea_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk("R10 ea_flag after reset", ea_flag, 1'b0);
        chk("R10 irq after reset", irq, 1'b0);
        chk("R10 char_accept after reset", char_accept, 1'b0);

        // R1 R2 R3 R4 R5 R6: sweep of every sampling tick in both phases
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 10; k++) begin
                int unsigned m = 46 * (k + 1) - 1;
                int unsigned c = sat(m);
                enter_phase(p[0]);
                repeat (m) @(negedge clk);
                chk(p ? "R5 char_accept high phase" : "R1/R3 char_accept low phase",
                    char_accept, !(p == 0 && c < 200));
                io_line = 1'b0;
                @(negedge clk);
                chk(p ? "R4/R5 flag at tick high phase" : "R1/R2/R3 flag at tick low phase",
                    ea_flag, exp_flag(p[0], c));
                chk("R9 irq tracks flag", irq, exp_flag(p[0], c));
                io_line = 1'b1;
            end
        end

        // R6: a low pulse between ticks is not seen; the next tick is
        enter_phase(1'b1);
        repeat (10) @(negedge clk);
        io_line = 1'b0;
        repeat (20) @(negedge clk);
        io_line = 1'b1;
        repeat (30) @(negedge clk);
        chk("R6 pulse between ticks ignored", ea_flag, 1'b0);
        repeat (91 - 60) @(negedge clk);
        io_line = 1'b0;
        @(negedge clk);
        chk("R6 start bit at position 91 flagged", ea_flag, 1'b1);
        io_line = 1'b1;

        // R8: sticky, then cleared by strobe
        repeat (25) @(negedge clk);
        chk("R8 flag stays set", ea_flag, 1'b1);
        ea_clr = 1'b1;
        @(negedge clk);
        ea_clr = 1'b0;
        chk("R8 flag cleared by strobe", ea_flag, 1'b0);
        chk("R9 irq cleared with flag", irq, 1'b0);

        // R8: set beats clear in the same cycle (low phase, position 229)
        enter_phase(1'b0);
        repeat (229) @(negedge clk);
        io_line = 1'b0;
        ea_clr  = 1'b1;
        @(negedge clk);
        ea_clr  = 1'b0;
        io_line = 1'b1;
        chk("R8 set wins over clear", ea_flag, 1'b1);

        // R7: position advances on clk_en only
        enter_phase(1'b0);
        for (int i = 0; i < 229; i++) begin
            clk_en = 1'b1;
            @(negedge clk);
            clk_en = 1'b0;
            @(negedge clk);
            if (i == 149)
                chk("R7 position counts enables (150 of 300 clocks)", char_accept, 1'b0);
        end
        chk("R7 char_accept at 229 enables", char_accept, 1'b1);
        clk_en  = 1'b1;
        io_line = 1'b0;
        @(negedge clk);
        io_line = 1'b1;
        chk("R7 gated count reaches flag window", ea_flag, 1'b1);

        // R7: a new edge restarts the position
        card_rst = 1'b1;
        @(negedge clk);
        card_rst = 1'b0;
        @(negedge clk);
        repeat (50) @(negedge clk);
        chk("R7 restart on edge drops char_accept", char_accept, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule